// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block gives a processor access to a space of 8-bit configuration registers through two I/O addresses. A write to the select address stores a register number. A read or write at the data address then reaches the register that number names. A display co-processor has a second, write-only path into the same space. That path reaches only register numbers below 0x80, and the block silently drops any co-processor write above that limit.

Register 0x02 is the reset control register. Writing it does not store anything. Instead it raises a hard-reset request pulse, a soft-reset request pulse, or both, for one clock cycle. The block obeys its own requests:

- **Hard reset:** clears the expansion-control register 0x80 and the bank register 0x04, and sets the user register 0x7F to 0xFF.
- **Soft reset:** copies the staged low nibble of register 0x80 into its live high nibble, and sets the user register 0x7F to 0xFF.

Register 0x04 accepts writes only while the config-mode input is high. Every other register number reads back 0xFF.

Top module: `cfg_regport`

## Requirements
- R1: A write with `io_addr` = 0x243B stores `io_wdata` as the selected register number. A write with `io_addr` = 0x253B writes the selected register, and a read at 0x253B returns the selected register's value on `io_rdata` in the same cycle.
- R2: A write of register 0x02 with bit 1 set gives a one-cycle `hard_rst_o` pulse in the cycle after the write. A write with bit 0 set gives a one-cycle `soft_rst_o` pulse in the cycle after the write. A write with neither bit set gives no pulse.
- R3: Whenever `hard_rst_o` is high, `soft_rst_o` is also high.
- R4: A co-processor write (`cop_wr`) to a register number below 0x80 takes effect at the next clock edge. A co-processor write to 0x80 or above has no effect.
- R5: Register 0x80 bits 7:4 are live and drive `exp_now_o` directly after a write. On the edge that ends a soft-reset pulse, bits 3:0 are copied into bits 7:4 and bits 3:0 keep their value. On a hard reset the whole register becomes 0x00.
- R6: Register 0x7F stores any byte written to it and becomes 0xFF on every soft or hard reset, including power-on reset.
- R7: Register 0x04 holds 7 bits, driven on `bank_o`, and bit 7 always reads 0. It is written only while `config_mode` is 1; otherwise writes to it leave it unchanged. A hard reset clears it.
- R8: A read at 0x253B of any register number other than 0x02, 0x04, 0x7F and 0x80 returns 0xFF. A read at any other I/O address also returns 0xFF.
- R9: When a processor data write and a co-processor write occur in the same cycle, the processor write is applied first. The co-processor write is applied one cycle later.
- R10: Register 0x02 reads as 0x00, because the request bits are not stored.
- R11: A read at 0x243B returns the selected register number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset, with the same effect as a hard reset |
| config_mode | input | 1 | High to allow writes to register 0x04 |
| io_wr | input | 1 | Processor I/O write strobe, one cycle per access |
| io_rd | input | 1 | Processor I/O read strobe |
| io_addr | input | 16 | Processor I/O address |
| io_wdata | input | 8 | Processor write data |
| io_rdata | output | 8 | Processor read data; 0xFF when no register is read |
| cop_wr | input | 1 | Co-processor register write strobe |
| cop_reg | input | 8 | Co-processor target register number |
| cop_data | input | 8 | Co-processor write data |
| hard_rst_o | output | 1 | One-cycle hard-reset request |
| soft_rst_o | output | 1 | One-cycle soft-reset request |
| exp_now_o | output | 4 | Live bits 7:4 of register 0x80 |
| bank_o | output | 7 | Contents of register 0x04 |

## Verification
The main path is tried with processor writes and reads on several register numbers. The reads include unimplemented numbers and the select address, which separates decoding errors from storage errors. Reset control is tried with three patterns on register 0x02: soft only, hard, and neither bit set. Comparing register 0x80 after each pattern tells the deferred nibble copy apart from the hard clear. The co-processor path is tried with a write below 0x80, a write at 0x80, and a write that collides with a processor write to the same register. Reading between the two edges of the collision shows that the processor write lands first. Register 0x04 is written with config mode both on and off.

// File: rtl/cfg_regport.sv
module cfg_regport #(
  parameter logic [15:0] SEL_PORT  = 16'h243B,
  parameter logic [15:0] DATA_PORT = 16'h253B,
  parameter logic [7:0]  REG_RST   = 8'h02,
  parameter logic [7:0]  REG_BANK  = 8'h04,
  parameter logic [7:0]  REG_USER  = 8'h7F,
  parameter logic [7:0]  REG_EXP   = 8'h80,
  parameter logic [7:0]  COP_LIMIT = 8'h80
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        config_mode,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic [15:0] io_addr,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  input  logic        cop_wr,
  input  logic [7:0]  cop_reg,
  input  logic [7:0]  cop_data,
  output logic        hard_rst_o,
  output logic        soft_rst_o,
  output logic [3:0]  exp_now_o,
  output logic [6:0]  bank_o
);

  logic [7:0] sel_q, exp_q, user_q;
  logic [6:0] bank_q;
  logic       hold_v;
  logic [7:0] hold_reg, hold_dat;
  logic       hard_q, soft_q;

  wire cpu_sel = io_wr && (io_addr == SEL_PORT);
  wire cpu_dat = io_wr && (io_addr == DATA_PORT);
  wire cop_v   = hold_v || (cop_wr && (cop_reg < COP_LIMIT));
  wire [7:0] cop_r = hold_v ? hold_reg : cop_reg;
  wire [7:0] cop_d = hold_v ? hold_dat : cop_data;

  wire       wen  = cpu_dat || cop_v;
  wire [7:0] wreg = cpu_dat ? sel_q : cop_r;
  wire [7:0] wdat = cpu_dat ? io_wdata : cop_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= '0;
      exp_q    <= '0;
      user_q   <= 8'hFF;
      bank_q   <= '0;
      hold_v   <= 1'b0;
      hold_reg <= '0;
      hold_dat <= '0;
      hard_q   <= 1'b0;
      soft_q   <= 1'b0;
    end else begin
      hard_q <= 1'b0;
      soft_q <= 1'b0;
      if (cpu_sel) sel_q <= io_wdata;
      hold_v <= cpu_dat && cop_v;
      if (cpu_dat && cop_v) begin
        hold_reg <= cop_r;
        hold_dat <= cop_d;
      end
      if (wen) begin
        case (wreg)
          REG_RST: begin
            hard_q <= wdat[1];
            soft_q <= wdat[1] | wdat[0];
          end
          REG_BANK: if (config_mode) bank_q <= wdat[6:0];
          REG_USER: user_q <= wdat;
          REG_EXP:  exp_q  <= wdat;
          default: ;
        endcase
      end
      if (hard_q) begin
        exp_q  <= '0;
        bank_q <= '0;
        user_q <= 8'hFF;
      end else if (soft_q) begin
        exp_q[7:4] <= exp_q[3:0];
        user_q     <= 8'hFF;
      end
    end
  end

  always_comb begin
    io_rdata = 8'hFF;
    if (io_rd && io_addr == SEL_PORT) io_rdata = sel_q;
    else if (io_rd && io_addr == DATA_PORT) begin
      case (sel_q)
        REG_RST:  io_rdata = 8'h00;
        REG_BANK: io_rdata = {1'b0, bank_q};
        REG_USER: io_rdata = user_q;
        REG_EXP:  io_rdata = exp_q;
        default:  io_rdata = 8'hFF;
      endcase
    end
  end

  assign hard_rst_o = hard_q;
  assign soft_rst_o = soft_q;
  assign exp_now_o  = exp_q[7:4];
  assign bank_o     = bank_q;

endmodule

module cfg_regport_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       config_mode,
  input logic       hard_rst_o,
  input logic       soft_rst_o,
  input logic [7:0] exp_q,
  input logic [7:0] user_q,
  input logic [6:0] bank_o
);
  p_hard_implies_soft_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hard_rst_o |-> soft_rst_o);
  p_hard_clears_exp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hard_rst_o |=> (exp_q == 8'h00));
  p_soft_copies_exp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst_o && !hard_rst_o) |=> (exp_q[7:4] == $past(exp_q[3:0])));
  p_reset_fills_user_r6: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |=> (user_q == 8'hFF));
  p_bank_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!config_mode && !hard_rst_o) |=> $stable(bank_o));
endmodule

bind cfg_regport cfg_regport_chk u_chk (
  .clk(clk), .rst_n(rst_n), .config_mode(config_mode),
  .hard_rst_o(hard_rst_o), .soft_rst_o(soft_rst_o),
  .exp_q(exp_q), .user_q(user_q), .bank_o(bank_o)
);

// File: tb/cfg_regport_test.sv
`timescale 1ns/1ps
module cfg_regport_test;
  localparam logic [15:0] SELP = 16'h243B;
  localparam logic [15:0] DATP = 16'h253B;

  logic clk = 0, rst_n = 0, config_mode = 0;
  logic io_wr = 0, io_rd = 0, cop_wr = 0;
  logic [15:0] io_addr = 0;
  logic [7:0] io_wdata = 0, cop_reg = 0, cop_data = 0;
  logic [7:0] io_rdata;
  logic hard_rst_o, soft_rst_o;
  logic [3:0] exp_now_o;
  logic [6:0] bank_o;

  int checks = 0, fails = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  cfg_regport uut (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && io_rd) begin
      if (exp_q.size() == 0) check(0, "scoreboard-empty", io_rdata, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(io_rdata === e, t, io_rdata, e);
      end
    end
  end

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    io_wr = 1; io_addr = a; io_wdata = d;
    @(posedge clk); #1;
    io_wr = 0;
  endtask

  task automatic wr_reg(input logic [7:0] r, input logic [7:0] d);
    io_write(SELP, r);
    io_write(DATP, d);
  endtask

  task automatic read_now(input logic [15:0] a, input logic [7:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    io_rd = 1; io_addr = a;
    @(posedge clk); #1;
    io_rd = 0;
  endtask

  task automatic rd_reg(input logic [7:0] r, input logic [7:0] e, input string tag);
    io_write(SELP, r);
    read_now(DATP, e, tag);
  endtask

  task automatic cop_write(input logic [7:0] r, input logic [7:0] d);
    @(posedge clk); #1;
    cop_wr = 1; cop_reg = r; cop_data = d;
    @(posedge clk); #1;
    cop_wr = 0;
  endtask

  initial begin
    #100000;
    check(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    check(hard_rst_o === 0 && soft_rst_o === 0, "R2 reset pulses idle", {hard_rst_o, soft_rst_o}, 0);
    rd_reg(8'h7F, 8'hFF, "R6 user after power-on");
    rd_reg(8'h80, 8'h00, "R5 exp after power-on");

    wr_reg(8'h7F, 8'h3C);
    rd_reg(8'h7F, 8'h3C, "R1 user write/read");
    io_write(SELP, 8'h10);
    read_now(SELP, 8'h10, "R11 select readback");
    read_now(DATP, 8'hFF, "R8 unimplemented 0x10");
    rd_reg(8'hC4, 8'hFF, "R8 unimplemented 0xC4");
    read_now(16'h00FE, 8'hFF, "R8 foreign address");
    rd_reg(8'h02, 8'h00, "R10 reg 0x02 reads zero");

    // bank register
    config_mode = 1;
    wr_reg(8'h04, 8'h95);
    rd_reg(8'h04, 8'h15, "R7 bank write, bit7 zero");
    check(bank_o === 7'h15, "R7 bank_o", bank_o, 7'h15);
    config_mode = 0;
    wr_reg(8'h04, 8'h22);
    rd_reg(8'h04, 8'h15, "R7 bank write ignored");

    // reg 0x80 immediate and deferred halves
    wr_reg(8'h80, 8'h5A);
    rd_reg(8'h80, 8'h5A, "R5 exp write");
    check(exp_now_o === 4'h5, "R5 exp_now immediate", exp_now_o, 5);

    // no-bit write to reset register
    io_write(SELP, 8'h02);
    io_write(DATP, 8'h00);
    check(hard_rst_o === 0 && soft_rst_o === 0, "R2 no pulse for zero", {hard_rst_o, soft_rst_o}, 0);

    // soft reset
    io_write(DATP, 8'h01);
    check(soft_rst_o === 1 && hard_rst_o === 0, "R2 soft pulse", {hard_rst_o, soft_rst_o}, 1);
    @(posedge clk); #1;
    check(soft_rst_o === 0, "R2 soft pulse one cycle", soft_rst_o, 0);
    rd_reg(8'h80, 8'hAA, "R5 soft copies low nibble");
    check(exp_now_o === 4'hA, "R5 exp_now after soft", exp_now_o, 4'hA);
    rd_reg(8'h7F, 8'hFF, "R6 user after soft");
    rd_reg(8'h04, 8'h15, "R7 bank survives soft");

    // co-processor path
    cop_write(8'h7F, 8'h33);
    rd_reg(8'h7F, 8'h33, "R4 cop write below limit");
    cop_write(8'h80, 8'h11);
    rd_reg(8'h80, 8'hAA, "R4 cop write at 0x80 dropped");

    // collision on reg 0x7F
    io_write(SELP, 8'h7F);
    @(posedge clk); #1;
    io_wr = 1; io_addr = DATP; io_wdata = 8'h44;
    cop_wr = 1; cop_reg = 8'h7F; cop_data = 8'h55;
    @(posedge clk); #1;
    io_wr = 0; cop_wr = 0;
    read_now(DATP, 8'h44, "R9 cpu write first");
    read_now(DATP, 8'h55, "R9 cop write one cycle later");

    // hard reset
    wr_reg(8'h80, 8'h3C);
    config_mode = 1;
    wr_reg(8'h04, 8'h07);
    io_write(SELP, 8'h02);
    io_write(DATP, 8'h02);
    check(hard_rst_o === 1, "R2 hard pulse", hard_rst_o, 1);
    check(soft_rst_o === 1, "R3 soft with hard", soft_rst_o, 1);
    config_mode = 0;
    rd_reg(8'h80, 8'h00, "R5 hard clears exp");
    rd_reg(8'h04, 8'h00, "R7 hard clears bank");
    rd_reg(8'h7F, 8'hFF, "R6 user after hard");

    // co-processor can trigger soft reset through reg 0x02
    wr_reg(8'h80, 8'h09);
    cop_write(8'h02, 8'h01);
    check(soft_rst_o === 1 && hard_rst_o === 0, "R4 cop soft request", {hard_rst_o, soft_rst_o}, 1);
    rd_reg(8'h80, 8'h99, "R5 cop soft copy");

    repeat (2) @(posedge clk);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule